// File: doc/BRIEF.md
# Serial Orderwire Byte Insertion Port

This block collects the three orderwire overhead bytes (E1, F1 and E2) for an outgoing STS-3 frame from external logic, one bit at a time. It produces a bit clock, a per-bit request strobe and a frame-alignment pulse. The external logic watches the request strobe. After each rising edge of the bit clock in a request slot, it places the next bit on a single serial data line. The block samples that line on the following falling edge of the bit clock, so the launch edge and the capture edge are never the same.

A one-cycle frame-start pulse from the frame timing generator restarts the slot counter. The alignment pulse occupies one whole bit slot. Immediately after it come 24 request slots carrying the E1 byte, then F1, then E2, each byte most significant bit first. The byte set is copied into the output register, with a one-cycle valid pulse, only once the last E2 bit has been sampled. The transport-overhead inserter therefore never sees a mix of two frames. A frame restarted before all 24 bits have arrived sets a sticky overrun flag, which is cleared by writing one. The reset is asynchronous and active-low. Its release is expected to be synchronous to `clk`.

Top module: `ow_insert_port`

## Requirements
- R1: While reset is asserted, all three byte outputs, the valid pulse and the overrun flag are 0. From reset until the first frame-start, the bit clock, request strobe and alignment pulse stay low.
- R2: After a frame-start, the bit clock runs with a period of 2*HALF_DIV clock cycles. Each period begins with HALF_DIV cycles high.
- R3: The alignment pulse is high for exactly one bit period, in slot LEAD_SLOTS after the frame-start. It falls at the start of the first request slot.
- R4: Exactly 24 request slots occur per frame, contiguous, in slots LEAD_SLOTS+1 to LEAD_SLOTS+24.
- R5: The serial input is sampled in the first clock cycle after the bit clock falls within a request slot, never at the rising edge.
- R6: Bits are assembled most significant bit first. The first 8 bits of a frame form E1, the next 8 form F1 and the last 8 form E2.
- R7: The byte outputs change only in the cycle after the 24th bit is sampled, with the valid output high for exactly that one cycle. A frame cut short by a new frame-start leaves the outputs and valid untouched.
- R8: With the serial input held at 0, a complete frame yields E1 = F1 = E2 = 8'h00.
- R9: A frame-start that arrives after an earlier frame-start, but before the 24th bit of that frame has been sampled, sets the overrun flag. The flag then holds until a cycle with the clear input high. A new set in the same cycle as a clear takes priority. The first frame-start after reset and a frame-start after a completed frame do not set it.
- R10: A frame-start restarts slot counting, so that collection after an aborted frame is correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame-start from the frame timing generator |
| ow_sdi | input | 1 | Serial orderwire data from external logic |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| oh_clk | output | 1 | Overhead bit clock to external logic |
| ow_req | output | 1 | Request strobe, high for each bit slot that expects a bit |
| ow_fp | output | 1 | Alignment pulse, one slot before the first E1 bit |
| e1_byte | output | 8 | Last completed E1 byte |
| f1_byte | output | 8 | Last completed F1 byte |
| e2_byte | output | 8 | Last completed E2 byte |
| ow_valid | output | 1 | One-cycle pulse when the byte outputs update |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench acts as the external logic: it changes the data line right after each rising edge of the bit clock in a request slot. A design that sampled on the launch edge would therefore capture each bit one slot late and shift the bytes by a bit. Frames are aborted mid-collection to catch a design that exposes a half-filled byte set, raises valid early, or fails to raise the overrun flag. A clean restart then confirms that slot counting resumes at zero. The alignment pulse is checked for its width and for its position in the slot just before the first request, which catches an off-by-one lead. A frame fed all zeros, frames fed asymmetric byte patterns and the count of requests per frame expose bit-order, byte-order and slot-count errors.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int unsigned OW_BYTES = 3;
  localparam int unsigned OW_BITS  = 8 * OW_BYTES;

  typedef struct packed {
    logic [7:0] e1;
    logic [7:0] f1;
    logic [7:0] e2;
  } ow_bytes_t;
endpackage

// File: rtl/ow_timing.sv
module ow_timing #(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned LEAD_SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  output logic run,
  output logic oh_clk,
  output logic ow_req,
  output logic ow_fp,
  output logic samp,
  output logic samp_last
);
  localparam int unsigned PER        = 2 * HALF_DIV;
  localparam int unsigned DW         = (PER > 2) ? $clog2(PER) : 1;
  localparam int unsigned SLOT_FIRST = LEAD_SLOTS + 1;
  localparam int unsigned SLOT_LAST  = LEAD_SLOTS + ow_pkg::OW_BITS;
  localparam int unsigned SLOT_IDLE  = SLOT_LAST + 1;
  localparam int unsigned BW         = $clog2(SLOT_IDLE + 1);

  logic          run_q, run_d;
  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] slot_q, slot_d;
  logic          wrap;

  assign wrap = (div_q == DW'(PER - 1));

  always_comb begin
    run_d  = run_q;
    div_d  = div_q;
    slot_d = slot_q;
    if (frame_start) begin
      run_d  = 1'b1;
      div_d  = '0;
      slot_d = '0;
    end else if (run_q) begin
      div_d = wrap ? '0 : div_q + 1'b1;
      if (wrap && (slot_q != BW'(SLOT_IDLE))) begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      div_q  <= div_d;
      slot_q <= slot_d;
    end
  end

  assign run       = run_q;
  assign oh_clk    = run_q && (div_q < DW'(HALF_DIV));
  assign ow_fp     = run_q && (slot_q == BW'(LEAD_SLOTS));
  assign ow_req    = run_q && (slot_q >= BW'(SLOT_FIRST)) && (slot_q <= BW'(SLOT_LAST));
  assign samp      = ow_req && (div_q == DW'(HALF_DIV));
  assign samp_last = samp && (slot_q == BW'(SLOT_LAST));

  // R3: first request slot directly follows the alignment slot
  p_fp_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ow_req) |-> $past(ow_fp));

  // R5: capture happens just after the bit clock has fallen
  p_samp_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> (!oh_clk && $past(oh_clk)));
endmodule

// File: rtl/ow_shifter.sv
module ow_shifter
  import ow_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      samp,
  input  logic      samp_last,
  input  logic      sdi,
  output ow_bytes_t bytes,
  output logic      valid
);
  logic [OW_BITS-1:0] shift_q, shift_d;
  ow_bytes_t          out_q, out_d;
  logic               valid_d;

  always_comb begin
    shift_d = samp ? {shift_q[OW_BITS-2:0], sdi} : shift_q;
    out_d   = samp_last ? ow_bytes_t'(shift_d) : out_q;
    valid_d = samp_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      out_q   <= '0;
      valid   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      out_q   <= out_d;
      valid   <= valid_d;
    end
  end

  assign bytes = out_q;

  // R7: output bytes move only together with the valid pulse
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(out_q));

  // R7: valid lasts a single cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/ow_status.sv
module ow_status (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic run,
  input  logic samp_last,
  input  logic clr,
  output logic flag
);
  logic done_q, done_d;
  logic flag_d;
  logic early;

  assign early = frame_start && run && !(done_q || samp_last);

  always_comb begin
    done_d = done_q;
    if (frame_start)    done_d = 1'b0;
    else if (samp_last) done_d = 1'b1;
    flag_d = flag;
    if (clr)   flag_d = 1'b0;
    if (early) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      done_q <= done_d;
      flag   <= flag_d;
    end
  end

  // R9: flag is sticky until cleared
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R9: no overrun from a frame-start that follows a completed frame
  p_no_false_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && frame_start && done_q) |=> !flag);
endmodule

// File: rtl/ow_insert_port.sv
module ow_insert_port #(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned LEAD_SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       ow_sdi,
  input  logic       ovr_clr,
  output logic       oh_clk,
  output logic       ow_req,
  output logic       ow_fp,
  output logic [7:0] e1_byte,
  output logic [7:0] f1_byte,
  output logic [7:0] e2_byte,
  output logic       ow_valid,
  output logic       ovr_flag
);
  import ow_pkg::*;

  logic      run, samp, samp_last;
  ow_bytes_t bytes;

  ow_timing #(.HALF_DIV(HALF_DIV), .LEAD_SLOTS(LEAD_SLOTS)) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .run         (run),
    .oh_clk      (oh_clk),
    .ow_req      (ow_req),
    .ow_fp       (ow_fp),
    .samp        (samp),
    .samp_last   (samp_last)
  );

  ow_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp      (samp),
    .samp_last (samp_last),
    .sdi       (ow_sdi),
    .bytes     (bytes),
    .valid     (ow_valid)
  );

  ow_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .run         (run),
    .samp_last   (samp_last),
    .clr         (ovr_clr),
    .flag        (ovr_flag)
  );

  assign e1_byte = bytes.e1;
  assign f1_byte = bytes.f1;
  assign e2_byte = bytes.e2;

  // R1: strobes stay quiet until the counter has been started
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!ow_req && !ow_fp && !oh_clk));
endmodule

// File: tb/ow_insert_port_tb.sv
`timescale 1ns/1ps
module ow_insert_port_tb;
  localparam int H    = 2;
  localparam int LEAD = 2;
  localparam int GAP  = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic ow_sdi = 1'b0;
  logic ovr_clr = 1'b0;
  logic oh_clk, ow_req, ow_fp, ow_valid, ovr_flag;
  logic [7:0] e1_byte, f1_byte, e2_byte;

  always #2 clk = ~clk;

  ow_insert_port #(.HALF_DIV(H), .LEAD_SLOTS(LEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ow_sdi(ow_sdi),
    .ovr_clr(ovr_clr), .oh_clk(oh_clk), .ow_req(ow_req), .ow_fp(ow_fp),
    .e1_byte(e1_byte), .f1_byte(f1_byte), .e2_byte(e2_byte),
    .ow_valid(ow_valid), .ovr_flag(ovr_flag)
  );

  int n_vec = 0;
  int n_err = 0;
  logic [23:0] exp_q[$];
  logic [23:0] cur_bits = '0;
  int frame_id = 0;
  int seen_id  = 0;
  int idx = 0;
  int fp_cnt = 0;
  int hi_cnt = 0;
  bit fs_in_hi = 1'b0;
  bit fp_prev = 1'b0, fp_cur = 1'b0;
  logic prev_clk = 1'b0;
  logic [23:0] prev_out = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // external logic model and monitor, all on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_id != seen_id) begin
        seen_id = frame_id;
        idx = 0;
        fp_cnt = 0;
      end
      if (ow_fp) fp_cnt++;
      if (oh_clk) begin
        if (!prev_clk) begin
          fp_prev = fp_cur;
          fp_cur  = ow_fp;
          if (ow_req && idx < 24) begin
            if (idx == 0) begin
              chk(fp_prev && !ow_fp, "R3 alignment slot precedes first request", {30'd0, fp_prev, ow_fp}, 32'h2);
              chk(fp_cnt == 2*H, "R3 alignment width", fp_cnt, 2*H);
            end
            ow_sdi <= cur_bits[23-idx];
            idx++;
          end else if (ow_req) begin
            chk(0, "R4 more than 24 requests", idx + 1, 24);
          end
        end
        hi_cnt++;
      end else if (prev_clk) begin
        if (!fs_in_hi) chk(hi_cnt == H, "R2 bit clock high phase", hi_cnt, H);
        hi_cnt = 0;
        fs_in_hi = 1'b0;
      end
      prev_clk = oh_clk;
      if (ow_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected update", {8'd0, e1_byte, f1_byte, e2_byte}, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({e1_byte, f1_byte, e2_byte} == e, "R6 byte set", {8'd0, e1_byte, f1_byte, e2_byte}, {8'd0, e});
        end
      end else begin
        chk({e1_byte, f1_byte, e2_byte} == prev_out, "R7 hold without valid",
            {8'd0, e1_byte, f1_byte, e2_byte}, {8'd0, prev_out});
      end
      prev_out = {e1_byte, f1_byte, e2_byte};
    end
  end

  task automatic start_frame(input logic [23:0] bits);
    @(posedge clk); #1;
    cur_bits = bits;
    frame_start = 1'b1;
    frame_id++;
    if (oh_clk) fs_in_hi = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic run_frame(input logic [23:0] bits, input string req);
    start_frame(bits);
    exp_q.push_back(bits);
    repeat (GAP) @(posedge clk);
    #1;
    chk(idx == 24, req, idx, 24);
  endtask

  initial begin
    #3000000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({e1_byte, f1_byte, e2_byte, ow_valid, ovr_flag} == 26'd0, "R1 reset outputs",
        {6'd0, e1_byte, f1_byte, e2_byte, ow_valid, ovr_flag}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk({oh_clk, ow_req, ow_fp} == 3'b000, "R1 strobes idle before frame-start",
          {29'd0, oh_clk, ow_req, ow_fp}, 0);
    end

    run_frame(24'hA53C81, "R4 request count frame 1");
    @(negedge clk);
    chk(ovr_flag == 1'b0, "R9 no overrun on first frame-start", ovr_flag, 0);
    run_frame(24'h000000, "R8 request count zero frame");
    run_frame(24'hFF005A, "R4 request count frame 3");
    @(negedge clk);
    chk(ovr_flag == 1'b0, "R9 no overrun after complete frames", ovr_flag, 0);
    chk({e1_byte, f1_byte, e2_byte} == 24'hFF005A, "R6 order E1 F1 E2",
        {8'd0, e1_byte, f1_byte, e2_byte}, 32'hFF005A);

    // aborted frame: restart mid-collection
    start_frame(24'h123456);
    repeat (60) @(posedge clk);
    run_frame(24'hDEADBE, "R10 request count after restart");
    @(negedge clk);
    chk(ovr_flag == 1'b1, "R9 overrun set by early frame-start", ovr_flag, 1);
    @(posedge clk); #1;
    ovr_clr = 1'b1;
    @(posedge clk); #1;
    ovr_clr = 1'b0;
    @(negedge clk);
    chk(ovr_flag == 1'b0, "R9 overrun cleared", ovr_flag, 0);
    chk({e1_byte, f1_byte, e2_byte} == 24'hDEADBE, "R10 bytes after restart",
        {8'd0, e1_byte, f1_byte, e2_byte}, 32'hDEADBE);

    run_frame(24'h80017F, "R5 request count edge-bit frame");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected updates seen", exp_q.size(), 0);
    chk({e1_byte, f1_byte, e2_byte} == 24'h80017F, "R5 MSB and LSB bits",
        {8'd0, e1_byte, f1_byte, e2_byte}, 32'h80017F);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule